// File: doc/BRIEF.md
# Control Transfer Descriptor Checker

This block judges a far control transfer before a segmented, ring-protected processor carries it out. Each request names the operation, the kind of descriptor the selector points at, and the table the descriptor came from. It also carries the flags word, the current privilege level, the selector's requested privilege level and the descriptor's privilege level. The block answers with a one-hot transfer class that tells the sequencer which flow to run: a plain far transfer, a call through a gate, an interrupt through a gate, a return to an outer ring, or one of the two kinds of task switch. When the combination is not allowed, it answers with a general protection fault flag instead.

A request is taken under a valid/ready handshake. The verdict is registered and held in a one-entry output stage until the consumer takes it. A new request can enter while the held verdict is being taken in the same cycle, so back-to-back requests run at one per clock. Fetching the descriptor, switching stacks and saving or restoring task state are left to other blocks.

Top module: `xfer_guard`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0 and in_ready is 1.
- R2: A request is taken on a clock edge where in_valid and in_ready are both 1. Its verdict shows on out_valid, out_class and out_gp after that edge. The verdict stays unchanged while out_ready is 0. in_ready equals (not out_valid) or out_ready.
- R3: Operation codes are JMP=0, CALL=1, RET=2, IRET=3, software interrupt=4, exception=5, external interrupt=6. Descriptor codes are code segment=0, call gate=1, interrupt gate=2, trap gate=3, task state segment=4, task gate=5. Table codes are GDT=0, LDT=1, IDT=2. Class bits are: bit0 same-ring far transfer, bit1 call gate, bit2 interrupt/trap gate, bit3 return to outer ring, bit4 switch through a task state segment, bit5 switch through a task gate. A JMP or CALL to a code segment from GDT or LDT whose descriptor privilege equals the current privilege gives class bit0.
- R4: RET, or IRET with the nested-task flag clear, to a code segment from GDT or LDT gives bit0 when the requested privilege equals the current one. It gives bit3 when the requested privilege is numerically larger. It faults when the requested privilege is numerically smaller.
- R5: Only CALL may use a call gate. The gate must come from GDT or LDT and pass the gate privilege test, and then the class is bit1.
- R6: An interrupt gate or trap gate is used only by a software interrupt, exception or external interrupt, and only from the IDT, giving bit2. A software interrupt must also pass the gate privilege test. Exceptions and external interrupts are exempt from it.
- R7: A task state segment descriptor gives bit4 only for JMP or CALL, and only when it comes from the GDT.
- R8: A task gate gives bit5 in three cases. The first is JMP or CALL with the gate from GDT or LDT that passes the privilege test. The second is a software interrupt (which passes the test), exception or external interrupt with the gate from the IDT. The third is IRET with the nested-task flag set and the gate from the IDT.
- R9: The nested-task flag is bit NT_BIT (default 14) of in_flags. Every other flags bit is ignored.
- R10: The effective privilege is the numerically larger of the current and requested privilege. The gate privilege test passes when the effective privilege is numerically less than or equal to the descriptor privilege.
- R11: Every other combination is a fault: out_gp is 1 and out_class is all zero. This includes table code 3, operation code 7 and descriptor codes 6 and 7.
- R12: When out_gp is 0, exactly one bit of out_class is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_desc | input | 3 | Referenced descriptor kind |
| in_table | input | 2 | Table the descriptor came from |
| in_flags | input | FLAGS_W | Flags word holding the nested-task bit |
| in_cpl | input | PL_W | Current privilege level |
| in_rpl | input | PL_W | Selector requested privilege level |
| in_dpl | input | PL_W | Descriptor privilege level |
| out_valid | output | 1 | Verdict held |
| out_ready | input | 1 | Consumer takes the verdict |
| out_class | output | 6 | One-hot transfer class, zero on fault |
| out_gp | output | 1 | General protection fault |

## Verification
The bench uses the default parameters: a 16-bit flags word with the nested-task flag at bit 14, and 2-bit privilege levels. This puts all four rings within reach, so the bench can drive cases where the effective privilege comes from the requested level rather than the current one, and returns to an outer ring. Noise is placed on the other flags bits so that reading the wrong bit shows up. Back-pressure runs check that a verdict stays held and that a request taken in the cycle the output is consumed is not lost.

// File: rtl/xfer_guard_pkg.sv
package xfer_guard_pkg;

    typedef enum logic [2:0] {
        OP_JMP    = 3'd0,
        OP_CALL   = 3'd1,
        OP_RET    = 3'd2,
        OP_IRET   = 3'd3,
        OP_SWINT  = 3'd4,
        OP_EXCEPT = 3'd5,
        OP_EXTINT = 3'd6,
        OP_BAD    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        DK_CODE    = 3'd0,
        DK_CALLG   = 3'd1,
        DK_INTG    = 3'd2,
        DK_TRAPG   = 3'd3,
        DK_TSS     = 3'd4,
        DK_TASKG   = 3'd5,
        DK_OTHER6  = 3'd6,
        DK_OTHER7  = 3'd7
    } desc_e;

    typedef enum logic [1:0] {
        TB_GLOBAL = 2'd0,
        TB_LOCAL  = 2'd1,
        TB_INTR   = 2'd2,
        TB_BAD    = 2'd3
    } tbl_e;

    localparam int CLS_W = 6;

    localparam logic [CLS_W-1:0] CLS_NONE   = 6'b000000;
    localparam logic [CLS_W-1:0] CLS_SAME   = 6'b000001;
    localparam logic [CLS_W-1:0] CLS_CGATE  = 6'b000010;
    localparam logic [CLS_W-1:0] CLS_IGATE  = 6'b000100;
    localparam logic [CLS_W-1:0] CLS_OUTER  = 6'b001000;
    localparam logic [CLS_W-1:0] CLS_TSSSW  = 6'b010000;
    localparam logic [CLS_W-1:0] CLS_TGATE  = 6'b100000;

    typedef struct packed {
        logic             vld;
        logic [CLS_W-1:0] cls;
        logic             gp;
    } verdict_t;

endpackage

// File: rtl/xfer_guard_priv.sv
module xfer_guard_priv #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] dpl,
    input  logic            exempt,
    output logic            gate_pass,
    output logic            rpl_same,
    output logic            rpl_outer,
    output logic            dpl_same
);
    logic [PL_W-1:0] epl;

    always_comb begin
        // effective level: the less privileged (numerically larger) of the two
        epl       = (cpl > rpl) ? cpl : rpl;
        gate_pass = exempt || (epl <= dpl);
        rpl_same  = (rpl == cpl);
        rpl_outer = (rpl > cpl);
        dpl_same  = (dpl == cpl);
    end
endmodule

// File: rtl/xfer_guard_rules.sv
module xfer_guard_rules
    import xfer_guard_pkg::*;
(
    input  op_e              op,
    input  desc_e            desc,
    input  tbl_e             tbl,
    input  logic             nt,
    input  logic             gate_pass,
    input  logic             rpl_same,
    input  logic             rpl_outer,
    input  logic             dpl_same,
    output logic [CLS_W-1:0] cls,
    output logic             gp
);
    logic from_gl;
    logic from_idt;
    logic is_jc;
    logic is_intr;
    logic is_ret_in_task;

    always_comb begin
        from_gl        = (tbl == TB_GLOBAL) || (tbl == TB_LOCAL);
        from_idt       = (tbl == TB_INTR);
        is_jc          = (op == OP_JMP) || (op == OP_CALL);
        is_intr        = (op == OP_SWINT) || (op == OP_EXCEPT) || (op == OP_EXTINT);
        is_ret_in_task = (op == OP_RET) || ((op == OP_IRET) && !nt);

        cls = CLS_NONE;
        unique case (desc)
            DK_CODE: begin
                if (from_gl) begin
                    if (is_jc && dpl_same) begin
                        cls = CLS_SAME;
                    end else if (is_ret_in_task) begin
                        if (rpl_same) begin
                            cls = CLS_SAME;
                        end else if (rpl_outer) begin
                            cls = CLS_OUTER;
                        end
                    end
                end
            end
            DK_CALLG: begin
                if ((op == OP_CALL) && from_gl && gate_pass) begin
                    cls = CLS_CGATE;
                end
            end
            DK_INTG, DK_TRAPG: begin
                if (is_intr && from_idt && gate_pass) begin
                    cls = CLS_IGATE;
                end
            end
            DK_TSS: begin
                if (is_jc && (tbl == TB_GLOBAL)) begin
                    cls = CLS_TSSSW;
                end
            end
            DK_TASKG: begin
                if (is_jc && from_gl && gate_pass) begin
                    cls = CLS_TGATE;
                end else if ((is_intr || ((op == OP_IRET) && nt)) && from_idt && gate_pass) begin
                    cls = CLS_TGATE;
                end
            end
            default: cls = CLS_NONE;
        endcase
        gp = (cls == CLS_NONE);
    end
endmodule

// File: rtl/xfer_guard_stage.sv
module xfer_guard_stage
    import xfer_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CLS_W-1:0] cls_i,
    input  logic             gp_i,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CLS_W-1:0] out_class,
    output logic             out_gp
);
    verdict_t st_d;
    verdict_t st_q;
    logic     take;

    always_comb begin
        in_ready = !st_q.vld || out_ready;
        take     = in_valid && in_ready;
        st_d     = st_q;
        if (take) begin
            st_d.vld = 1'b1;
            st_d.cls = cls_i;
            st_d.gp  = gp_i;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, cls: CLS_NONE, gp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_class = st_q.cls;
    assign out_gp    = st_q.gp;

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_gp)); // R2
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R2
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid); // R1
endmodule

// File: rtl/xfer_guard.sv
module xfer_guard
    import xfer_guard_pkg::*;
#(
    parameter int FLAGS_W = 16,
    parameter int NT_BIT  = 14,
    parameter int PL_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [2:0]         in_op,
    input  logic [2:0]         in_desc,
    input  logic [1:0]         in_table,
    input  logic [FLAGS_W-1:0] in_flags,
    input  logic [PL_W-1:0]    in_cpl,
    input  logic [PL_W-1:0]    in_rpl,
    input  logic [PL_W-1:0]    in_dpl,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [5:0]         out_class,
    output logic               out_gp
);
    op_e              op;
    desc_e            desc;
    tbl_e             tbl;
    logic             nt;
    logic             exempt;
    logic             gate_pass;
    logic             rpl_same;
    logic             rpl_outer;
    logic             dpl_same;
    logic [CLS_W-1:0] cls;
    logic             gp;

    always_comb begin
        op     = op_e'(in_op);
        desc   = desc_e'(in_desc);
        tbl    = tbl_e'(in_table);
        nt     = in_flags[NT_BIT];
        exempt = (op == OP_EXCEPT) || (op == OP_EXTINT) || (op == OP_IRET);
    end

    xfer_guard_priv #(.PL_W(PL_W)) u_priv (
        .cpl       (in_cpl),
        .rpl       (in_rpl),
        .dpl       (in_dpl),
        .exempt    (exempt),
        .gate_pass (gate_pass),
        .rpl_same  (rpl_same),
        .rpl_outer (rpl_outer),
        .dpl_same  (dpl_same)
    );

    xfer_guard_rules u_rules (
        .op        (op),
        .desc      (desc),
        .tbl       (tbl),
        .nt        (nt),
        .gate_pass (gate_pass),
        .rpl_same  (rpl_same),
        .rpl_outer (rpl_outer),
        .dpl_same  (dpl_same),
        .cls       (cls),
        .gp        (gp)
    );

    xfer_guard_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .cls_i     (cls),
        .gp_i      (gp),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_class (out_class),
        .out_gp    (out_gp)
    );

    AST_CLASS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(out_class)); // R12
    AST_PASS_HAS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_gp |-> $countones(out_class) == 1); // R12
    AST_FAULT_NO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_gp |-> out_class == '0); // R11
    AST_TSS_GLOBAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_desc == 3'd4 && in_table != 2'd0 |=> out_gp); // R7
    AST_IGATE_IDT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_desc == 3'd2 || in_desc == 3'd3) && in_table != 2'd2 |=> out_gp); // R6
    AST_CGATE_CALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_desc == 3'd1 && in_op != 3'd1 |=> out_gp); // R5
endmodule

// File: tb/xfer_guard_bench.sv
module xfer_guard_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OJ = 3'd0, OC = 3'd1, OR = 3'd2, OI = 3'd3,
                           OS = 3'd4, OE = 3'd5, OX = 3'd6, OB = 3'd7;
    localparam logic [2:0] DC = 3'd0, DG = 3'd1, DI = 3'd2, DT = 3'd3,
                           DS = 3'd4, DK = 3'd5, DD = 3'd6;
    localparam logic [1:0] TG = 2'd0, TL = 2'd1, TI = 2'd2, TX = 2'd3;
    localparam logic [5:0] KN = 6'b000000, KS = 6'b000001, KC = 6'b000010,
                           KI = 6'b000100, KO = 6'b001000, KT = 6'b010000,
                           KG = 6'b100000;

    // {req, op, desc, table, nt, cpl, rpl, dpl, expected class}
    localparam int NV = 29;
    localparam logic [24:0] VECS [NV] = '{
        {4'd3,  OJ, DC, TG, 1'b0, 2'd0, 2'd0, 2'd0, KS}, // R3
        {4'd3,  OC, DC, TL, 1'b0, 2'd2, 2'd2, 2'd2, KS}, // R3
        {4'd3,  OJ, DC, TG, 1'b0, 2'd3, 2'd3, 2'd0, KN}, // R3
        {4'd3,  OJ, DC, TI, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R3
        {4'd4,  OR, DC, TG, 1'b0, 2'd0, 2'd0, 2'd0, KS}, // R4
        {4'd4,  OR, DC, TL, 1'b0, 2'd0, 2'd3, 2'd3, KO}, // R4
        {4'd4,  OI, DC, TG, 1'b0, 2'd1, 2'd2, 2'd2, KO}, // R4
        {4'd9,  OI, DC, TG, 1'b1, 2'd0, 2'd0, 2'd0, KN}, // R9
        {4'd4,  OR, DC, TG, 1'b0, 2'd2, 2'd1, 2'd1, KN}, // R4
        {4'd5,  OC, DG, TG, 1'b0, 2'd3, 2'd3, 2'd3, KC}, // R5
        {4'd10, OC, DG, TL, 1'b0, 2'd1, 2'd3, 2'd2, KN}, // R10
        {4'd10, OC, DG, TL, 1'b0, 2'd3, 2'd1, 2'd2, KN}, // R10
        {4'd5,  OC, DG, TG, 1'b0, 2'd1, 2'd1, 2'd2, KC}, // R5
        {4'd5,  OJ, DG, TG, 1'b0, 2'd0, 2'd0, 2'd3, KN}, // R5
        {4'd6,  OS, DI, TI, 1'b0, 2'd3, 2'd3, 2'd3, KI}, // R6
        {4'd6,  OS, DT, TI, 1'b0, 2'd3, 2'd3, 2'd0, KN}, // R6
        {4'd6,  OE, DT, TI, 1'b0, 2'd3, 2'd3, 2'd0, KI}, // R6
        {4'd6,  OX, DI, TG, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R6
        {4'd7,  OC, DS, TG, 1'b0, 2'd0, 2'd0, 2'd0, KT}, // R7
        {4'd7,  OJ, DS, TL, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R7
        {4'd7,  OR, DS, TG, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R7
        {4'd8,  OJ, DK, TL, 1'b0, 2'd1, 2'd1, 2'd1, KG}, // R8
        {4'd8,  OI, DK, TI, 1'b1, 2'd0, 2'd0, 2'd0, KG}, // R8
        {4'd8,  OI, DK, TI, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R8
        {4'd8,  OX, DK, TI, 1'b0, 2'd0, 2'd0, 2'd0, KG}, // R8
        {4'd11, OC, DD, TG, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R11
        {4'd11, OB, DC, TG, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R11
        {4'd11, OJ, DC, TX, 1'b0, 2'd0, 2'd0, 2'd0, KN}, // R11
        {4'd8,  OS, DK, TI, 1'b0, 2'd2, 2'd2, 2'd1, KN}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [2:0]  in_desc = '0;
    logic [1:0]  in_table = '0;
    logic [15:0] in_flags = '0;
    logic [1:0]  in_cpl = '0;
    logic [1:0]  in_rpl = '0;
    logic [1:0]  in_dpl = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [5:0]  out_class;
    logic        out_gp;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xfer_guard u_xfer_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_desc(in_desc), .in_table(in_table), .in_flags(in_flags),
        .in_cpl(in_cpl), .in_rpl(in_rpl), .in_dpl(in_dpl),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_class(out_class), .out_gp(out_gp)
    );

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_verdict(input string req, input logic [5:0] exp);
        checks++;
        if (out_valid !== 1'b1 || out_class !== exp || out_gp !== (exp == 6'b0)) begin
            fails++;
            $display("FAIL %s: actual valid=%0b class=%b gp=%0b expected valid=1 class=%b gp=%0b",
                     req, out_valid, out_class, out_gp, exp, (exp == 6'b0));
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [2:0] dk, input logic [1:0] tb,
                         input logic [15:0] fl, input logic [1:0] c, input logic [1:0] r,
                         input logic [1:0] d);
        in_op = op; in_desc = dk; in_table = tb; in_flags = fl;
        in_cpl = c; in_rpl = r; in_dpl = d; in_valid = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2: watchdog expired, actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit("R1", "out_valid in reset", out_valid, 1'b0);
        check_bit("R1", "in_ready in reset", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", "out_valid after reset", out_valid, 1'b0);
        check_bit("R1", "in_ready after reset", in_ready, 1'b1);

        // table walk, one request per cycle with the consumer always ready
        out_ready = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            logic [15:0] fl;
            v  = VECS[i];
            fl = (16'hA5A5 & ~16'h4000) | (v[12] ? 16'h4000 : 16'h0000);
            drive(v[20:18], v[17:15], v[14:13], fl, v[11:10], v[9:8], v[7:6]);
            @(negedge clk);
            in_valid = 1'b0;
            checks++;
            if (out_valid !== 1'b1 || out_class !== v[5:0] || out_gp !== (v[5:0] == 6'b0)) begin
                fails++;
                $display("FAIL R%0d vector %0d: actual valid=%0b class=%b gp=%0b expected class=%b gp=%0b",
                         v[24:21], i, out_valid, out_class, out_gp, v[5:0], (v[5:0] == 6'b0));
            end
        end
        @(negedge clk);
        check_bit("R2", "drained", out_valid, 1'b0);

        // R9: nested-task bit position, other flags bits ignored
        drive(OI, DC, TG, 16'hBFFF, 2'd0, 2'd0, 2'd0);
        @(negedge clk); in_valid = 1'b0;
        check_verdict("R9 nt clear with noise", KS);
        drive(OI, DK, TI, 16'h4000, 2'd0, 2'd0, 2'd0);
        @(negedge clk); in_valid = 1'b0;
        check_verdict("R9 nt set alone", KG);
        drive(OI, DK, TI, 16'hBFFF, 2'd0, 2'd0, 2'd0);
        @(negedge clk); in_valid = 1'b0;
        check_verdict("R9 nt clear task gate", KN);
        @(negedge clk);

        // R2: back-pressure and hand-over in the consume cycle
        out_ready = 1'b0;
        drive(OC, DS, TG, 16'h0000, 2'd0, 2'd0, 2'd0);
        @(negedge clk);
        check_verdict("R2 first held", KT);
        drive(OJ, DC, TG, 16'h0000, 2'd0, 2'd0, 2'd0);
        check_bit("R2", "in_ready while stalled", in_ready, 1'b0);
        repeat (2) @(negedge clk);
        check_verdict("R2 held under stall", KT);
        out_ready = 1'b1;
        #1;
        check_bit("R2", "in_ready on consume", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check_verdict("R2 second after hand-over", KS);
        @(negedge clk);
        check_bit("R2", "empty after consume", out_valid, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule